// File: doc/BRIEF.md
# Multi-Mode Receive DMA Channel

This block moves received characters from a serial controller into a circular buffer in memory. Bytes arrive over a valid/ready handshake that also carries end-of-frame and abort flags. They pass through a four-entry FIFO, and a write engine stores each one at the current buffer pointer. The pointer walks from a programmed base address up to a programmed bound and then returns to the base.

Software picks one of four receive modes, and each mode has its own interrupt cause.

- **Frame chaining**: a header slot is set aside at the start of every frame. When the frame ends or is aborted, the header is filled in with the frame's length and a completion flag.
- **Periodic**: an interrupt is raised after every n stored bytes, using a byte counter that reloads itself.
- **Idle timeout**: an interrupt is raised when the gap after the last received character reaches a programmed length.
- **Character match**: an interrupt is raised when a stored byte equals any of four programmed match values.

In the last three modes no length is reported. Software works it out from the address pointer.

Every cause sets a sticky status bit, which software clears by writing a one to it. The interrupt line is the OR of the status bits that are unmasked.

Top module: `rx_dma_chan`

## Requirements
- R1: After reset the channel is disabled, with `in_ready`, `mem_req` and `irq` all low. Every register reads as zero.
- R2: A byte is accepted only while the channel is enabled and fewer than four bytes are pending. `in_ready` is low when four are pending. Bytes reach memory in the order they were accepted.
- R3: Each stored byte is written at the pointer as a word whose low 8 bits hold the byte and whose upper bits are zero. The pointer then advances by one. A write at the bound address is followed by the next write at the base address. The pointer can be read at offset 5.
- R4: In chaining mode (mode 0), the pointer slot at the first byte of a frame is reserved for the header, and data starts in the next slot. After the byte flagged end-of-frame is stored, the header is written to the reserved slot with bit 15 = 0, bit 14 = 1 and bits 11:0 = the number of data bytes. Status bit 0 is then set. The next frame's header slot directly follows the last data slot.
- R5: In chaining mode, a byte flagged abort is not stored. It closes the frame with a header of bit 15 = 1, bit 14 = 0 and bits 11:0 = the number of data bytes stored so far.
- R6: In periodic mode (mode 1), status bit 1 is set on every n-th stored byte, where n is the value at offset 6. The working counter reloads from n each time and also loads when the channel is enabled.
- R7: In timeout mode (mode 2), status bit 2 is set exactly T cycles after the edge that accepted a character, where T is the value at offset 7, provided no further character is accepted in that time. A newly accepted character restarts the count. Nothing fires before the first character, and it fires only once per idle gap.
- R8: In match mode (mode 3), status bit 3 is set in the cycle a byte equal to any of the values at offsets 8 to 11 is written to memory. It is not set while that byte is still waiting in the FIFO.
- R9: Writing a one to a bit of the status register (offset 2) clears that bit, except that a hardware set in the same cycle wins. `irq` is high when any status bit is set and its bit in the mask register (offset 1) is one.
- R10: Only the selected mode's status bit can be set. For example, a byte equal to a match value stored in periodic or timeout mode leaves status bit 3 clear.
- R11: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_addr` and `mem_wdata` hold their values.
- R12: The register map is as follows. Offset 0 is control: bit 0 enables the channel and bits 2:1 select the mode. Offset 1 is the mask, offset 2 the status, offset 3 the base, offset 4 the bound, offset 5 the pointer, offset 6 the periodic count, offset 7 the timeout, and offsets 8 to 11 the match values. All of these read back what was written, except status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| in_eof | input | 1 | Byte is the last of a frame |
| in_abort | input | 1 | Frame aborted; byte carries no data |
| in_ready | output | 1 | Channel can accept a byte |
| mem_req | output | 1 | Memory write request |
| mem_gnt | input | 1 | Memory write accepted this cycle |
| mem_addr | output | AW | Write address |
| mem_wdata | output | MW | Write data (byte or header word) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data (combinational) |
| irq | output | 1 | Maskable interrupt |

## Verification
The hardware set of a status bit and a software write-one-clear of the same bit can fall in the same cycle. The bench provokes this in periodic mode. It clears bit 1 after a reload, then sends two more bytes to leave the counter at one. It then sends the next byte and places the clear strobe on the exact edge at which that byte is stored. The outcome is judged at the ports by reading the status register afterwards, which must still show bit 1 set, together with `irq` high. A plain clear of that same bit in a quiet cycle is checked separately, so that a design which ignores clears altogether is also caught.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

   typedef enum logic [1:0] {
      MODE_CHAIN  = 2'd0,
      MODE_PERIOD = 2'd1,
      MODE_IDLE   = 2'd2,
      MODE_MATCH  = 2'd3
   } rx_mode_e;

   // status / mask bit positions
   localparam int unsigned EV_FRAME  = 0;
   localparam int unsigned EV_PERIOD = 1;
   localparam int unsigned EV_IDLE   = 2;
   localparam int unsigned EV_MATCH  = 3;
   localparam int unsigned EV_N      = 4;

   // register offsets
   localparam logic [3:0] RA_CTRL   = 4'd0;
   localparam logic [3:0] RA_MASK   = 4'd1;
   localparam logic [3:0] RA_STAT   = 4'd2;
   localparam logic [3:0] RA_BASE   = 4'd3;
   localparam logic [3:0] RA_BOUND  = 4'd4;
   localparam logic [3:0] RA_PTR    = 4'd5;
   localparam logic [3:0] RA_COUNT  = 4'd6;
   localparam logic [3:0] RA_TMO    = 4'd7;
   localparam logic [3:0] RA_MATCH0 = 4'd8;

endpackage

// File: rtl/rxdma_fifo.sv
module rxdma_fifo #(
   parameter int unsigned WIDTH = 10,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int unsigned PW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rxdma_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] slot [DEPTH];
   logic [PW-1:0]    wp, rp;
   logic [PW:0]      cnt;

   always_ff @(posedge clk) begin
      if (push) slot[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
      end
   end

   assign dout  = slot[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == (PW+1)'(DEPTH));

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/rxdma_events.sv
module rxdma_events import rxdma_pkg::*; #(
   parameter int unsigned CW     = 12,
   parameter int unsigned TW     = 16,
   parameter int unsigned NMATCH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  rx_mode_e          mode,
   input  logic              byte_wr,
   input  logic [7:0]        byte_val,
   input  logic              rx_push,
   input  logic              cnt_load,
   input  logic [CW-1:0]     cnt_reload,
   input  logic [TW-1:0]     tmo_limit,
   input  logic [NMATCH*8-1:0] match_flat,
   output logic              ev_period,
   output logic              ev_idle,
   output logic              ev_match
);
   // periodic byte counter
   logic          en_q;
   logic [CW-1:0] wcnt;
   logic          per_act;

   assign per_act   = en && (mode == MODE_PERIOD);
   assign ev_period = per_act && byte_wr && (wcnt <= CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         wcnt <= '0;
      end else begin
         en_q <= en;
         if (cnt_load || (en && !en_q))
            wcnt <= cnt_reload;
         else if (per_act && byte_wr)
            wcnt <= (wcnt <= CW'(1)) ? cnt_reload : wcnt - 1'b1;
      end
   end

   // inter-character idle timer
   logic          armed;
   logic [TW-1:0] tcnt;
   logic          idle_act;

   assign idle_act = en && (mode == MODE_IDLE);
   assign ev_idle  = idle_act && armed && !rx_push && (tcnt == tmo_limit - TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         tcnt  <= '0;
      end else if (!idle_act) begin
         armed <= 1'b0;
         tcnt  <= '0;
      end else if (rx_push) begin
         armed <= 1'b1;
         tcnt  <= '0;
      end else if (ev_idle) begin
         armed <= 1'b0;
      end else if (armed) begin
         tcnt <= tcnt + 1'b1;
      end
   end

   // character comparators
   logic [NMATCH-1:0] hit;
   generate
      for (genvar i = 0; i < NMATCH; i++) begin : g_cmp
         assign hit[i] = (byte_val == match_flat[i*8 +: 8]);
      end
   endgenerate

   assign ev_match = en && (mode == MODE_MATCH) && byte_wr && (|hit);

   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (per_act && byte_wr && wcnt == CW'(1) && !cnt_load) |=> (wcnt == $past(cnt_reload)));
   assert_idle_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_idle |=> !ev_idle);

endmodule

// File: rtl/rx_dma_chan.sv
module rx_dma_chan import rxdma_pkg::*; #(
   parameter int unsigned AW         = 16,
   parameter int unsigned MW         = 16,
   parameter int unsigned RW         = 16,
   parameter int unsigned CW         = 12,
   parameter int unsigned TW         = 16,
   parameter int unsigned FIFO_DEPTH = 4,
   parameter int unsigned NMATCH     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [7:0]    in_data,
   input  logic          in_eof,
   input  logic          in_abort,
   output logic          in_ready,
   output logic          mem_req,
   input  logic          mem_gnt,
   output logic [AW-1:0] mem_addr,
   output logic [MW-1:0] mem_wdata,
   input  logic          reg_we,
   input  logic [3:0]    reg_addr,
   input  logic [RW-1:0] reg_wdata,
   output logic [RW-1:0] reg_rdata,
   output logic          irq
);
   localparam int unsigned EW = 10;   // {abort, eof, byte}

   generate
      if (AW > RW || CW > RW || TW > RW) begin : g_bad_rw
         $error("rx_dma_chan: register width too small");
      end
      if (MW < CW + 2 || MW < 8) begin : g_bad_mw
         $error("rx_dma_chan: memory word too narrow for header");
      end
      if (NMATCH < 1 || NMATCH > 4) begin : g_bad_nmatch
         $error("rx_dma_chan: NMATCH must be 1..4");
      end
   endgenerate

   // ---------------- registers ----------------
   logic                en;
   rx_mode_e            mode;
   logic [EV_N-1:0]     mask, stat, ev, clr_bits;
   logic [AW-1:0]       base, bound, ptr;
   logic [CW-1:0]       reload;
   logic [TW-1:0]       tmo;
   logic [NMATCH*8-1:0] match_flat;

   // ---------------- FIFO ----------------
   logic          push, pop, f_empty, f_full;
   logic [EW-1:0] f_dout;
   logic          h_abort, h_eof;
   logic [7:0]    h_byte;

   assign in_ready = en && !f_full;
   assign push     = in_valid && in_ready;

   rxdma_fifo #(.WIDTH(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push),
      .din({in_abort, in_eof, in_data}), .pop(pop),
      .dout(f_dout), .empty(f_empty), .full(f_full)
   );
   assign {h_abort, h_eof, h_byte} = f_dout;

   // ---------------- write engine ----------------
   logic          chain, frame_open, hdr_phase, hdr_abort;
   logic [AW-1:0] hdr_addr, ptr_nxt;
   logic [CW-1:0] fcnt;
   logic          reserve, data_go, abort_go, byte_wr, hdr_done;
   logic          wr_ptr_reg;
   logic [MW-1:0] hdr_word, data_word;

   assign chain    = (mode == MODE_CHAIN);
   assign ptr_nxt  = (ptr == bound) ? base : ptr + 1'b1;
   assign reserve  = en && chain && !frame_open && !hdr_phase && !f_empty;
   assign abort_go = en && chain && frame_open && !hdr_phase && !f_empty && h_abort;
   assign data_go  = en && !hdr_phase && !f_empty && (!chain || (frame_open && !h_abort));
   assign byte_wr  = data_go && mem_gnt;
   assign hdr_done = en && hdr_phase && mem_gnt;
   assign pop      = byte_wr || abort_go;
   assign wr_ptr_reg = reg_we && (reg_addr == RA_PTR);

   always_comb begin
      hdr_word            = '0;
      hdr_word[CW-1:0]    = fcnt;
      hdr_word[MW-1]      = hdr_abort;
      hdr_word[MW-2]      = !hdr_abort;
      data_word           = '0;
      data_word[7:0]      = h_byte;
   end

   assign mem_req   = data_go || (en && hdr_phase);
   assign mem_addr  = hdr_phase ? hdr_addr : ptr;
   assign mem_wdata = hdr_phase ? hdr_word : data_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_open <= 1'b0;
         hdr_phase  <= 1'b0;
         hdr_abort  <= 1'b0;
         hdr_addr   <= '0;
         fcnt       <= '0;
      end else if (!en) begin
         frame_open <= 1'b0;
         hdr_phase  <= 1'b0;
      end else if (reserve) begin
         frame_open <= 1'b1;
         hdr_addr   <= ptr;
         fcnt       <= '0;
      end else if (abort_go) begin
         hdr_phase <= 1'b1;
         hdr_abort <= 1'b1;
      end else if (byte_wr && chain) begin
         fcnt <= fcnt + 1'b1;
         if (h_eof) begin
            hdr_phase <= 1'b1;
            hdr_abort <= 1'b0;
         end
      end else if (hdr_done) begin
         hdr_phase  <= 1'b0;
         frame_open <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (wr_ptr_reg)
         ptr <= reg_wdata[AW-1:0];
      else if (reserve || byte_wr)
         ptr <= ptr_nxt;
   end

   // ---------------- events ----------------
   logic ev_period, ev_idle, ev_match;

   rxdma_events #(.CW(CW), .TW(TW), .NMATCH(NMATCH)) u_events (
      .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
      .byte_wr(byte_wr), .byte_val(h_byte), .rx_push(push),
      .cnt_load(reg_we && reg_addr == RA_COUNT), .cnt_reload(reload),
      .tmo_limit(tmo), .match_flat(match_flat),
      .ev_period(ev_period), .ev_idle(ev_idle), .ev_match(ev_match)
   );

   always_comb begin
      ev           = '0;
      ev[EV_FRAME] = hdr_done && chain;
      ev[EV_PERIOD]= ev_period;
      ev[EV_IDLE]  = ev_idle;
      ev[EV_MATCH] = ev_match;
   end

   assign clr_bits = (reg_we && reg_addr == RA_STAT) ? reg_wdata[EV_N-1:0] : '0;
   assign irq      = |(stat & mask);

   // ---------------- register file ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en         <= 1'b0;
         mode       <= MODE_CHAIN;
         mask       <= '0;
         stat       <= '0;
         base       <= '0;
         bound      <= '0;
         reload     <= '0;
         tmo        <= '0;
         match_flat <= '0;
      end else begin
         stat <= (stat & ~clr_bits) | ev;
         if (reg_we) begin
            case (reg_addr)
               RA_CTRL: begin
                  en   <= reg_wdata[0];
                  mode <= rx_mode_e'(reg_wdata[2:1]);
               end
               RA_MASK:  mask   <= reg_wdata[EV_N-1:0];
               RA_BASE:  base   <= reg_wdata[AW-1:0];
               RA_BOUND: bound  <= reg_wdata[AW-1:0];
               RA_COUNT: reload <= reg_wdata[CW-1:0];
               RA_TMO:   tmo    <= reg_wdata[TW-1:0];
               default: ;
            endcase
            for (int i = 0; i < NMATCH; i++)
               if (reg_addr == RA_MATCH0 + 4'(i))
                  match_flat[i*8 +: 8] <= reg_wdata[7:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL:  reg_rdata[2:0] = {mode, en};
         RA_MASK:  reg_rdata[EV_N-1:0] = mask;
         RA_STAT:  reg_rdata[EV_N-1:0] = stat;
         RA_BASE:  reg_rdata = RW'(base);
         RA_BOUND: reg_rdata = RW'(bound);
         RA_PTR:   reg_rdata = RW'(ptr);
         RA_COUNT: reg_rdata = RW'(reload);
         RA_TMO:   reg_rdata = RW'(tmo);
         default: ;
      endcase
      for (int i = 0; i < NMATCH; i++)
         if (reg_addr == RA_MATCH0 + 4'(i))
            reg_rdata[7:0] = match_flat[i*8 +: 8];
   end

   // ---------------- assertions ----------------
   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_wr && mem_addr == bound && !reg_we) |=> (ptr == base));
   assert_hdr_after_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_wr && chain && h_eof && !reg_we) |=> (mem_req && mem_addr == $past(hdr_addr)));
   assert_abort_not_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      abort_go |-> !(mem_req && mem_gnt));
   assert_match_on_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_match |-> (mem_req && mem_gnt && !hdr_phase));
   assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|stat) |=> ((stat & $past(stat & ~clr_bits)) == $past(stat & ~clr_bits)));
   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt && !reg_we) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

endmodule

// File: tb/rx_dma_chan_tb.sv
module rx_dma_chan_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_eof = 1'b0, in_abort = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready, mem_req, irq;
   logic        mem_gnt = 1'b1;
   logic [15:0] mem_addr, mem_wdata;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0, reg_rdata;

   always #2 clk = ~clk;   // 250 MHz

   rx_dma_chan u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_eof(in_eof), .in_abort(in_abort), .in_ready(in_ready),
      .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   localparam logic [15:0] BASE  = 16'h0100;
   localparam logic [15:0] BOUND = 16'h0107;

   int nchk = 0, nfail = 0;
   logic [15:0] exp_ptr;
   logic [15:0] rd;

   typedef struct { logic [15:0] a; logic [15:0] d; } exp_t;
   exp_t sb[$];

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   function automatic logic [15:0] nxt(logic [15:0] p);
      return (p == BOUND) ? BASE : p + 16'd1;
   endfunction

   task automatic exp_push(logic [15:0] a, logic [15:0] d);
      exp_t e;
      e.a = a; e.d = d;
      sb.push_back(e);
   endtask

   // monitor: compare every accepted write against the scoreboard
   always @(negedge clk) begin : mon
      exp_t e;
      if (rst_n && mem_req && mem_gnt) begin
         nchk++;
         if (sb.size() == 0) begin
            nfail++;
            $display("FAIL R3 write actual=%h:%h expected=none", mem_addr, mem_wdata);
         end else begin
            e = sb.pop_front();
            if (mem_addr !== e.a || mem_wdata !== e.d) begin
               nfail++;
               $display("FAIL R3/R4 write actual=%h:%h expected=%h:%h",
                        mem_addr, mem_wdata, e.a, e.d);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wreg(logic [3:0] a, logic [15:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rreg(logic [3:0] a, output logic [15:0] d);
      reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
      @(posedge clk); #1;
   endtask

   task automatic send(logic [7:0] d, logic eof, logic ab);
      logic ok;
      in_valid = 1'b1; in_data = d; in_eof = eof; in_abort = ab;
      ok = 1'b0;
      while (!ok) begin
         @(negedge clk);
         ok = in_ready;
         @(posedge clk); #1;
      end
      in_valid = 1'b0; in_eof = 1'b0; in_abort = 1'b0;
   endtask

   // expect a chained frame: header slot, data, header word
   task automatic chain_frame(int n, logic [7:0] seed, logic ab);
      logic [15:0] h;
      h = exp_ptr;
      exp_ptr = nxt(exp_ptr);
      for (int i = 0; i < n; i++) begin
         exp_push(exp_ptr, {8'h00, seed + 8'(i)});
         exp_ptr = nxt(exp_ptr);
      end
      exp_push(h, {ab, ~ab, 2'b00, 12'(n)});
      for (int i = 0; i < n; i++)
         send(seed + 8'(i), (!ab && i == n - 1), 1'b0);
      if (ab) send(8'h00, 1'b0, 1'b1);
   endtask

   task automatic store(logic [7:0] d);
      exp_push(exp_ptr, {8'h00, d});
      exp_ptr = nxt(exp_ptr);
      send(d, 1'b0, 1'b0);
   endtask

   initial begin : stim
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 in_ready", 32'(in_ready), 0);
      check("R1 mem_req", 32'(mem_req), 0);
      check("R1 irq", 32'(irq), 0);
      rst_n = 1'b1;
      idle(1);
      rreg(4'd2, rd); check("R1 stat", 32'(rd), 0);
      rreg(4'd0, rd); check("R1 ctrl", 32'(rd), 0);

      // configuration (R12)
      wreg(4'd3, BASE);
      wreg(4'd4, BOUND);
      wreg(4'd5, BASE);
      wreg(4'd1, 16'h000F);
      wreg(4'd8, 16'h0011);
      wreg(4'd9, 16'h0022);
      wreg(4'd10, 16'h0033);
      wreg(4'd11, 16'h0044);
      rreg(4'd4, rd); check("R12 bound readback", 32'(rd), 32'(BOUND));
      rreg(4'd10, rd); check("R12 match2 readback", 32'(rd), 32'h33);
      exp_ptr = BASE;

      // R4 chaining: complete frame
      wreg(4'd0, 16'h0001);
      chain_frame(3, 8'hA1, 1'b0);
      idle(4);
      rreg(4'd2, rd); check("R4 frame status", 32'(rd), 32'h1);
      check("R9 irq on frame", 32'(irq), 1);
      wreg(4'd2, 16'h0001);
      rreg(4'd2, rd); check("R9 plain clear", 32'(rd), 0);

      // R5 abort, then R3 wrap across bound
      chain_frame(2, 8'hB1, 1'b1);
      idle(4);
      chain_frame(2, 8'hC1, 1'b0);
      idle(4);
      rreg(4'd5, rd); check("R3 pointer after wrap", 32'(rd), 32'(exp_ptr));

      // R2 / R11 / R6 / R10: periodic with stalled memory
      wreg(4'd0, 16'h0000);
      idle(1);
      check("R2 not ready when disabled", 32'(in_ready), 0);
      wreg(4'd2, 16'h000F);
      wreg(4'd5, BASE);
      exp_ptr = BASE;
      wreg(4'd6, 16'd3);
      wreg(4'd0, 16'h0003);
      mem_gnt = 1'b0;
      exp_push(exp_ptr, 16'h0011); exp_ptr = nxt(exp_ptr); send(8'h11, 0, 0);
      exp_push(exp_ptr, 16'h0020); exp_ptr = nxt(exp_ptr); send(8'h20, 0, 0);
      exp_push(exp_ptr, 16'h0021); exp_ptr = nxt(exp_ptr); send(8'h21, 0, 0);
      exp_push(exp_ptr, 16'h0022); exp_ptr = nxt(exp_ptr); send(8'h22, 0, 0);
      @(negedge clk);
      check("R2 in_ready low when four pending", 32'(in_ready), 0);
      check("R11 req during stall", 32'(mem_req), 1);
      check("R11 addr during stall", 32'(mem_addr), 32'(BASE));
      idle(3);
      @(negedge clk);
      check("R11 addr held", 32'(mem_addr), 32'(BASE));
      check("R11 data held", 32'(mem_wdata), 32'h0011);
      @(posedge clk); #1;
      mem_gnt = 1'b1;
      idle(6);
      rreg(4'd2, rd); check("R6 period fired, R10 no match bit", 32'(rd), 32'h2);
      wreg(4'd2, 16'h000F);
      store(8'h30);
      idle(3);
      rreg(4'd2, rd); check("R6 no fire at fifth byte", 32'(rd), 0);
      store(8'h31);
      idle(3);
      rreg(4'd2, rd); check("R6 reload fires at sixth", 32'(rd), 32'h2);
      wreg(4'd2, 16'h0002);
      store(8'h32);
      store(8'h33);
      idle(3);
      // R9 collision: clear lands on the edge that stores the 9th byte
      exp_push(exp_ptr, 16'h0034); exp_ptr = nxt(exp_ptr);
      in_valid = 1'b1; in_data = 8'h34;
      @(posedge clk); #1;       // byte accepted here
      in_valid = 1'b0;
      reg_we = 1'b1; reg_addr = 4'd2; reg_wdata = 16'h0002;
      @(posedge clk); #1;       // byte stored and clear in the same edge
      reg_we = 1'b0;
      rreg(4'd2, rd); check("R9 set wins over clear", 32'(rd), 32'h2);
      check("R9 irq after collision", 32'(irq), 1);

      // R7 idle timeout
      wreg(4'd0, 16'h0000);
      wreg(4'd2, 16'h000F);
      wreg(4'd7, 16'd10);
      wreg(4'd0, 16'h0005);
      idle(30);
      rreg(4'd2, rd); check("R7 silent before first char", 32'(rd), 0);
      exp_push(exp_ptr, 16'h0011); exp_ptr = nxt(exp_ptr);
      reg_addr = 4'd2;
      send(8'h11, 0, 0);
      repeat (9) @(posedge clk);
      @(negedge clk);
      check("R7 not yet at T-1", 32'(reg_rdata), 0);
      @(negedge clk);
      check("R7 fires at T, R10 no match bit", 32'(reg_rdata), 32'h4);
      idle(30);
      wreg(4'd2, 16'h000F);
      idle(30);
      rreg(4'd2, rd); check("R7 once per idle gap", 32'(rd), 0);
      store(8'h50);
      idle(5);
      store(8'h51);
      reg_addr = 4'd2;
      repeat (9) @(posedge clk);
      @(negedge clk);
      check("R7 restarted by new char", 32'(reg_rdata), 0);
      @(negedge clk);
      check("R7 fires after restart", 32'(reg_rdata), 32'h4);
      @(posedge clk); #1;

      // R8 match
      wreg(4'd0, 16'h0000);
      wreg(4'd2, 16'h000F);
      wreg(4'd1, 16'h0000);
      wreg(4'd0, 16'h0007);
      store(8'h55);
      idle(3);
      rreg(4'd2, rd); check("R8 no match on other byte", 32'(rd), 0);
      mem_gnt = 1'b0;
      exp_push(exp_ptr, 16'h0033); exp_ptr = nxt(exp_ptr);
      send(8'h33, 0, 0);
      idle(3);
      rreg(4'd2, rd); check("R8 not set while pending", 32'(rd), 0);
      mem_gnt = 1'b1;
      idle(2);
      rreg(4'd2, rd); check("R8 set once stored", 32'(rd), 32'h8);
      check("R9 masked irq low", 32'(irq), 0);
      wreg(4'd1, 16'h0008);
      @(negedge clk);
      check("R9 unmasked irq high", 32'(irq), 1);
      @(posedge clk); #1;

      idle(4);
      check("R3 scoreboard drained", 32'(sb.size()), 0);
      finish_run();
   end

endmodule